// File: doc/BRIEF.md
# Virtual Interrupt Delivery Engine

This block holds the virtualized interrupt-controller state of one guest: a 256-entry request array, a 256-entry in-service array, the highest requesting vector, the vector currently in service, a task-priority byte and the processor-priority byte derived from the task priority and the in-service vector. A host-side sequencer issues one command at a time (deliver, end-of-interrupt, self-interrupt, task-priority write, interrupt-command low write, interrupt-command high write). The engine applies the command to the state, re-derives the processor priority where needed, decides whether an interrupt is pending, and raises an exit request with a kind and a qualification when the command cannot be handled inside the virtual state.

Every command takes exactly two cycles. In the first cycle the array bit for the affected vector is set or cleared. In the second, the most significant remaining set bit of the array is found by a word-wise scan and the scalar state, the pending flag and any exit or delivery pulse are registered together with a one-cycle completion strobe.

Top module: `vintr_engine`

## Requirements
- R1: After reset the requesting vector, in-service vector, task priority, processor priority, interrupt-command high word, pending flag, busy and all pulses are zero.
- R2: A command presented with cmd_valid_i while busy_o is low is accepted; busy_o is high the following cycle, done_o pulses the cycle after that, and any command presented while busy_o is high is dropped. Op codes: 0 deliver, 1 EOI, 2 self-interrupt, 3 task-priority write, 4 command-low write, 5 command-high write.
- R3: When pending is evaluated it becomes 1 only if intwin_exit_i is 0 and the upper nibble of the requesting vector is greater than the upper nibble of the processor priority; otherwise 0.
- R4: Processor priority takes the task priority when the task priority's upper nibble is at least the in-service vector's upper nibble, else the in-service vector with its low nibble forced to zero.
- R5: Deliver sets the in-service bit of the requesting vector, clears its request bit, makes it the in-service vector, sets processor priority to its upper nibble followed by zero, moves the requesting vector to the highest remaining request bit (0 if none), clears pending and pulses dlv_valid_o with the delivered vector.
- R6: EOI with vid_en_i high clears the in-service bit of the in-service vector, makes the highest remaining in-service bit (0 if none) the new in-service vector and recomputes processor priority by R4.
- R7: In an R6 EOI, if eoi_exit_map_i has the old vector's bit set, an exit of kind 2 with the old vector as qualification is raised and pending keeps its value; otherwise pending is re-evaluated.
- R8: EOI with vid_en_i low raises an exit of kind 3 with qualification 0x0B0 and changes no state.
- R9: Self-interrupt sets the request bit of cmd_data_i[7:0], raises the requesting vector to that vector if it is not lower, and re-evaluates pending.
- R10: Task-priority write stores cmd_data_i[7:0]; with vid_en_i high it recomputes processor priority and re-evaluates pending; with vid_en_i low it raises an exit of kind 1 with qualification 0 when the new upper nibble is below tpr_thresh_i, and leaves processor priority alone.
- R11: A command-low write acts as a self-interrupt only when vid_en_i is high, (value & 0xFFF3B700) is zero, bits [19:18] equal 01 and bits [7:0] are at least 16; otherwise it raises an exit of kind 3 with qualification 0x300.
- R12: A command-high write keeps only bits [31:24] of cmd_data_i in icr_hi_o, the rest zero, and raises no exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | 32 | Vector, priority or command word |
| vid_en_i | input | 1 | Virtual delivery enabled |
| intwin_exit_i | input | 1 | Interrupt-window exit enabled (suppresses pending) |
| tpr_thresh_i | input | 4 | Task-priority threshold |
| eoi_exit_map_i | input | 256 | Per-vector EOI exit enables |
| busy_o | output | 1 | Command in its second cycle |
| done_o | output | 1 | Command completed, results valid |
| pending_o | output | 1 | Virtual interrupt pending |
| rvi_o | output | 8 | Requesting vector |
| svi_o | output | 8 | In-service vector |
| vtpr_o | output | 8 | Task priority |
| vppr_o | output | 8 | Processor priority |
| icr_hi_o | output | 32 | Interrupt-command high word |
| dlv_valid_o | output | 1 | Delivery pulse |
| dlv_vector_o | output | 8 | Delivered vector |
| exit_valid_o | output | 1 | Exit request pulse |
| exit_kind_o | output | 2 | 1 threshold, 2 virtualized EOI, 3 register write |
| exit_qual_o | output | 12 | Exit qualification |

## Verification
The two functions that can meet in one cycle are acceptance of a new command and completion of the one in flight: the bench holds a deliver command valid across both of its cycles, so the second cycle offers it again while the first completes, and the scoreboard expects exactly one completion with one delivered vector and a requesting vector advanced only once. The second overlap is the virtualized-EOI exit against pending re-evaluation on the same completion: an EOI is issued whose old vector has its exit bit set while the remaining request would make pending true, and the bench expects the exit with pending left at its earlier value.

// File: rtl/vintr_pkg.sv
package vintr_pkg;
  typedef enum logic [2:0] {
    OP_DELIVER   = 3'd0,
    OP_EOI       = 3'd1,
    OP_SELF_IPI  = 3'd2,
    OP_TPR_WR    = 3'd3,
    OP_ICR_LO_WR = 3'd4,
    OP_ICR_HI_WR = 3'd5
  } vi_op_e;

  typedef enum logic [1:0] {
    EXIT_NONE    = 2'd0,
    EXIT_TPR_THR = 2'd1,
    EXIT_VEOI    = 2'd2,
    EXIT_APIC_WR = 2'd3
  } vi_exit_e;

  localparam logic [11:0] QUAL_EOI    = 12'h0B0;
  localparam logic [11:0] QUAL_ICR_LO = 12'h300;
  localparam logic [31:0] ICR_RSV_MASK = 32'hFFF3_B700;
endpackage

// File: rtl/vintr_msb_scan.sv
module vintr_msb_scan #(
  parameter int NBITS = 256,
  parameter int WORD  = 32,
  localparam int IW   = $clog2(NBITS),
  localparam int BW   = $clog2(WORD),
  localparam int NW   = NBITS / WORD
) (
  input  logic [NBITS-1:0] vec_i,
  output logic [IW-1:0]    top_o
);
  logic [NW-1:0] nz;
  logic [BW-1:0] msb_w [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign nz[w] = |vec_i[w*WORD +: WORD];
    always_comb begin
      msb_w[w] = '0;
      for (int b = 0; b < WORD; b++)
        if (vec_i[w*WORD + b]) msb_w[w] = BW'(b);
    end
  end

  // higher words override lower ones
  always_comb begin
    top_o = '0;
    for (int w = 0; w < NW; w++)
      if (nz[w]) top_o = IW'(w * WORD) | IW'(msb_w[w]);
  end
endmodule

// File: rtl/vintr_ppr.sv
module vintr_ppr #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] tpr_i,
  input  logic [VW-1:0] svi_i,
  output logic [VW-1:0] ppr_o
);
  always_comb begin
    if (tpr_i[VW-1:4] >= svi_i[VW-1:4]) ppr_o = tpr_i;
    else                                ppr_o = {svi_i[VW-1:4], 4'h0};
  end
endmodule

// File: rtl/vintr_icr_check.sv
module vintr_icr_check
  import vintr_pkg::*;
(
  input  logic [31:0] icr_i,
  input  logic        vid_en_i,
  output logic        ok_o
);
  always_comb begin
    ok_o = vid_en_i && ((icr_i & ICR_RSV_MASK) == 32'h0) &&
           (icr_i[19:18] == 2'b01) && (icr_i[7:0] >= 8'd16);
  end
endmodule

// File: rtl/vintr_engine.sv
module vintr_engine
  import vintr_pkg::*;
#(
  parameter int VW   = 8,
  parameter int WORD = 32,
  localparam int NVEC = 1 << VW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [31:0]     cmd_data_i,
  input  logic            vid_en_i,
  input  logic            intwin_exit_i,
  input  logic [3:0]      tpr_thresh_i,
  input  logic [NVEC-1:0] eoi_exit_map_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            pending_o,
  output logic [VW-1:0]   rvi_o,
  output logic [VW-1:0]   svi_o,
  output logic [VW-1:0]   vtpr_o,
  output logic [VW-1:0]   vppr_o,
  output logic [31:0]     icr_hi_o,
  output logic            dlv_valid_o,
  output logic [VW-1:0]   dlv_vector_o,
  output logic            exit_valid_o,
  output logic [1:0]      exit_kind_o,
  output logic [11:0]     exit_qual_o
);
  logic [NVEC-1:0] irr_q, isr_q;
  logic [VW-1:0]   rvi_q, svi_q, vtpr_q, vppr_q, vec_q, dlv_vec_q;
  logic [31:0]     icr_hi_q;
  logic            busy_q, done_q, pend_q, vid_q, icr_ok_q, dlv_q, exit_q;
  logic [1:0]      exit_kind_q;
  logic [11:0]     exit_qual_q;
  vi_op_e          op_q, op_in;

  logic            accept, icr_ok;
  logic [VW-1:0]   irr_top, isr_top, ppr_tpr, ppr_svi, ppr_new, rvi_max;

  assign op_in  = vi_op_e'(cmd_op_i);
  assign accept = cmd_valid_i && !busy_q;

  vintr_icr_check u_icr (.icr_i(cmd_data_i), .vid_en_i(vid_en_i), .ok_o(icr_ok));

  vintr_msb_scan #(.NBITS(NVEC), .WORD(WORD)) u_irr_scan (.vec_i(irr_q), .top_o(irr_top));
  vintr_msb_scan #(.NBITS(NVEC), .WORD(WORD)) u_isr_scan (.vec_i(isr_q), .top_o(isr_top));

  // task-priority write uses the new TPR with the current SVI; EOI uses the new SVI
  assign ppr_tpr = (op_q == OP_TPR_WR) ? vec_q : vtpr_q;
  assign ppr_svi = (op_q == OP_TPR_WR) ? svi_q : isr_top;
  vintr_ppr #(.VW(VW)) u_ppr (.tpr_i(ppr_tpr), .svi_i(ppr_svi), .ppr_o(ppr_new));

  assign rvi_max = (vec_q >= rvi_q) ? vec_q : rvi_q;

  function automatic logic eval_pend(input logic [VW-1:0] r, input logic [VW-1:0] p);
    return !intwin_exit_i && (r[VW-1:4] > p[VW-1:4]);
  endfunction

  // stage 1: array update and command capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q    <= '0;
      isr_q    <= '0;
      busy_q   <= 1'b0;
      op_q     <= OP_DELIVER;
      vec_q    <= '0;
      vid_q    <= 1'b0;
      icr_ok_q <= 1'b0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        op_q     <= op_in;
        vid_q    <= vid_en_i;
        icr_ok_q <= icr_ok;
        vec_q    <= cmd_data_i[VW-1:0];
        unique case (op_in)
          OP_DELIVER: begin
            irr_q[rvi_q] <= 1'b0;
            isr_q[rvi_q] <= 1'b1;
            vec_q        <= rvi_q;
          end
          OP_EOI: begin
            if (vid_en_i) isr_q[svi_q] <= 1'b0;
            vec_q <= svi_q;
          end
          OP_SELF_IPI: irr_q[cmd_data_i[VW-1:0]] <= 1'b1;
          OP_ICR_LO_WR: if (icr_ok) irr_q[cmd_data_i[VW-1:0]] <= 1'b1;
          OP_ICR_HI_WR: vec_q <= cmd_data_i[31:24];
          default: ;
        endcase
      end
    end
  end

  // stage 2: scan results, priorities, pending and exits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      rvi_q       <= '0;
      svi_q       <= '0;
      vtpr_q      <= '0;
      vppr_q      <= '0;
      pend_q      <= 1'b0;
      icr_hi_q    <= '0;
      dlv_q       <= 1'b0;
      dlv_vec_q   <= '0;
      exit_q      <= 1'b0;
      exit_kind_q <= EXIT_NONE;
      exit_qual_q <= '0;
    end else begin
      done_q <= busy_q;
      dlv_q  <= 1'b0;
      exit_q <= 1'b0;
      if (busy_q) begin
        unique case (op_q)
          OP_DELIVER: begin
            svi_q     <= vec_q;
            vppr_q    <= {vec_q[VW-1:4], 4'h0};
            rvi_q     <= irr_top;
            pend_q    <= 1'b0;
            dlv_q     <= 1'b1;
            dlv_vec_q <= vec_q;
          end
          OP_EOI: begin
            if (vid_q) begin
              svi_q  <= isr_top;
              vppr_q <= ppr_new;
              if (eoi_exit_map_i[vec_q]) begin
                exit_q      <= 1'b1;
                exit_kind_q <= EXIT_VEOI;
                exit_qual_q <= 12'(vec_q);
              end else begin
                pend_q <= eval_pend(rvi_q, ppr_new);
              end
            end else begin
              exit_q      <= 1'b1;
              exit_kind_q <= EXIT_APIC_WR;
              exit_qual_q <= QUAL_EOI;
            end
          end
          OP_SELF_IPI: begin
            rvi_q  <= rvi_max;
            pend_q <= eval_pend(rvi_max, vppr_q);
          end
          OP_TPR_WR: begin
            vtpr_q <= vec_q;
            if (vid_q) begin
              vppr_q <= ppr_new;
              pend_q <= eval_pend(rvi_q, ppr_new);
            end else if (vec_q[VW-1:4] < tpr_thresh_i) begin
              exit_q      <= 1'b1;
              exit_kind_q <= EXIT_TPR_THR;
              exit_qual_q <= '0;
            end
          end
          OP_ICR_LO_WR: begin
            if (icr_ok_q) begin
              rvi_q  <= rvi_max;
              pend_q <= eval_pend(rvi_max, vppr_q);
            end else begin
              exit_q      <= 1'b1;
              exit_kind_q <= EXIT_APIC_WR;
              exit_qual_q <= QUAL_ICR_LO;
            end
          end
          OP_ICR_HI_WR: icr_hi_q <= {vec_q, 24'h0};
          default: ;
        endcase
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign pending_o    = pend_q;
  assign rvi_o        = rvi_q;
  assign svi_o        = svi_q;
  assign vtpr_o       = vtpr_q;
  assign vppr_o       = vppr_q;
  assign icr_hi_o     = icr_hi_q;
  assign dlv_valid_o  = dlv_q;
  assign dlv_vector_o = dlv_vec_q;
  assign exit_valid_o = exit_q;
  assign exit_kind_o  = exit_kind_q;
  assign exit_qual_o  = exit_qual_q;
endmodule

module vintr_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        pending_o,
  input logic [7:0]  rvi_o,
  input logic [7:0]  svi_o,
  input logic [7:0]  vppr_o,
  input logic [31:0] icr_hi_o,
  input logic        dlv_valid_o,
  input logic [7:0]  dlv_vector_o,
  input logic        exit_valid_o
);
  a_r2_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o && done_o);
  a_r2_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  a_r2_state_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rvi_o) && $stable(svi_o) && $stable(vppr_o) && $stable(pending_o));
  a_r2_pulses_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o || exit_valid_o) |-> done_o);
  a_r3_pending_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> rvi_o[7:4] > vppr_o[7:4]);
  a_r5_deliver_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> !pending_o && svi_o == dlv_vector_o && vppr_o == {dlv_vector_o[7:4], 4'h0});
  a_r12_icr_hi_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icr_hi_o[23:0] == 24'h0);
endmodule

bind vintr_engine vintr_engine_chk u_chk (.*);

// File: tb/tb_vintr_engine.sv
module tb_vintr_engine;
  logic         clk = 0, rst_n = 0;
  logic         cmd_valid = 0;
  logic [2:0]   cmd_op = 0;
  logic [31:0]  cmd_data = 0;
  logic         vid_en = 1, intwin = 0;
  logic [3:0]   thr = 0;
  logic [255:0] emap = '0;
  logic         busy, done, pend, dlv_v, ex_v;
  logic [7:0]   rvi, svi, vtpr, vppr, dlv_vec;
  logic [31:0]  icr_hi;
  logic [1:0]   ex_k;
  logic [11:0]  ex_q;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  vintr_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .vid_en_i(vid_en), .intwin_exit_i(intwin),
    .tpr_thresh_i(thr), .eoi_exit_map_i(emap), .busy_o(busy), .done_o(done),
    .pending_o(pend), .rvi_o(rvi), .svi_o(svi), .vtpr_o(vtpr), .vppr_o(vppr),
    .icr_hi_o(icr_hi), .dlv_valid_o(dlv_v), .dlv_vector_o(dlv_vec),
    .exit_valid_o(ex_v), .exit_kind_o(ex_k), .exit_qual_o(ex_q));

  typedef struct {
    string       req;
    logic        pend;
    logic [7:0]  rvi, svi, vtpr, vppr, dvec;
    logic [31:0] hi;
    logic        dlv, ex;
    logic [1:0]  kind;
    logic [11:0] qual;
  } exp_t;

  exp_t q[$];

  // reference model state
  logic [255:0] irr_m = '0, isr_m = '0;
  logic [7:0]   rvi_m = 0, svi_m = 0, vtpr_m = 0, vppr_m = 0;
  logic         pend_m = 0;
  logic [31:0]  hi_m = 0;

  function automatic logic [7:0] top(input logic [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return 8'(i);
    return 8'd0;
  endfunction

  function automatic logic [7:0] ppr(input logic [7:0] t, input logic [7:0] s);
    return (t[7:4] >= s[7:4]) ? t : {s[7:4], 4'h0};
  endfunction

  function automatic logic ev(input logic [7:0] r, input logic [7:0] p);
    return !intwin && (r[7:4] > p[7:4]);
  endfunction

  function automatic void fail(string req, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [31:0] d, input string req, input bit hold = 0);
    exp_t e;
    logic [7:0] v;
    bit ok;
    e.req = req; e.dlv = 0; e.ex = 0; e.kind = 0; e.qual = 0; e.dvec = 0;
    v = d[7:0];
    case (op)
      3'd0: begin
        v = rvi_m; irr_m[v] = 0; isr_m[v] = 1; svi_m = v; vppr_m = {v[7:4], 4'h0};
        rvi_m = top(irr_m); pend_m = 0; e.dlv = 1; e.dvec = v;
      end
      3'd1: begin
        if (vid_en) begin
          v = svi_m; isr_m[v] = 0; svi_m = top(isr_m); vppr_m = ppr(vtpr_m, svi_m);
          if (emap[v]) begin e.ex = 1; e.kind = 2; e.qual = 12'(v); end
          else pend_m = ev(rvi_m, vppr_m);
        end else begin e.ex = 1; e.kind = 3; e.qual = 12'h0B0; end
      end
      3'd2: begin
        irr_m[v] = 1; if (v >= rvi_m) rvi_m = v; pend_m = ev(rvi_m, vppr_m);
      end
      3'd3: begin
        vtpr_m = v;
        if (vid_en) begin vppr_m = ppr(vtpr_m, svi_m); pend_m = ev(rvi_m, vppr_m); end
        else if (v[7:4] < thr) begin e.ex = 1; e.kind = 1; e.qual = 0; end
      end
      3'd4: begin
        ok = vid_en && ((d & 32'hFFF3B700) == 0) && d[19:18] == 2'b01 && v >= 16;
        if (ok) begin irr_m[v] = 1; if (v >= rvi_m) rvi_m = v; pend_m = ev(rvi_m, vppr_m); end
        else begin e.ex = 1; e.kind = 3; e.qual = 12'h300; end
      end
      default: hi_m = {d[31:24], 24'h0};
    endcase
    e.pend = pend_m; e.rvi = rvi_m; e.svi = svi_m; e.vtpr = vtpr_m; e.vppr = vppr_m; e.hi = hi_m;
    q.push_back(e);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(negedge clk); if (!hold) cmd_valid = 0;
    @(negedge clk); cmd_valid = 0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (!done && (dlv_v || ex_v)) begin
      checks++; fail("R2", "pulse without done", {dlv_v, ex_v}, 0);
    end
    if (done) begin
      exp_t e;
      checks++;
      if (q.size() == 0) fail("R2", "unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        if (pend !== e.pend) fail(e.req, "pending", pend, e.pend);
        else if (rvi !== e.rvi) fail(e.req, "rvi", rvi, e.rvi);
        else if (svi !== e.svi) fail(e.req, "svi", svi, e.svi);
        else if (vtpr !== e.vtpr) fail(e.req, "vtpr", vtpr, e.vtpr);
        else if (vppr !== e.vppr) fail(e.req, "vppr", vppr, e.vppr);
        else if (icr_hi !== e.hi) fail(e.req, "icr_hi", icr_hi, e.hi);
        else if (dlv_v !== e.dlv) fail(e.req, "dlv_valid", dlv_v, e.dlv);
        else if (e.dlv && dlv_vec !== e.dvec) fail(e.req, "dlv_vector", dlv_vec, e.dvec);
        else if (ex_v !== e.ex) fail(e.req, "exit_valid", ex_v, e.ex);
        else if (e.ex && (ex_k !== e.kind || ex_q !== e.qual))
          fail(e.req, "exit kind/qual", {ex_k, ex_q}, {e.kind, e.qual});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fail("R2", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({pend, rvi, svi, vtpr, vppr, icr_hi, busy, done, dlv_v, ex_v} !== '0)
      fail("R1", "reset state", {pend, rvi, svi, vtpr, vppr}, 0);
    rst_n = 1;
    @(negedge clk);
    cmd(3'd2, 32'h45, "R9 self 45");
    cmd(3'd2, 32'h32, "R9 self lower 32");
    cmd(3'd0, 0, "R5 deliver 45");
    cmd(3'd2, 32'h81, "R9/R3 self 81");
    cmd(3'd0, 0, "R5 deliver 81");
    cmd(3'd1, 0, "R6 eoi 81");
    cmd(3'd3, 32'h70, "R4/R10 tpr 70");
    cmd(3'd3, 32'h10, "R4/R10 tpr 10");
    emap[8'h45] = 1;
    cmd(3'd1, 0, "R7 eoi exit 45");
    emap = '0;
    cmd(3'd4, 32'h0004_0060, "R11 icr valid 60");
    cmd(3'd4, 32'h0004_1070, "R11 icr reserved bit");
    cmd(3'd4, 32'h0004_000F, "R11 icr vector 0F");
    cmd(3'd4, 32'h0000_0070, "R11 icr shorthand 00");
    intwin = 1;
    cmd(3'd2, 32'h90, "R3 intwin masks pending");
    intwin = 0;
    cmd(3'd2, 32'h20, "R3 re-eval pending");
    cmd(3'd5, 32'h1234_5678, "R12 icr hi");
    // held deliver: second offer falls while busy and must be dropped
    cmd(3'd0, 0, "R2 held deliver", 1);
    cmd(3'd0, 0, "R5 deliver next");
    vid_en = 0; thr = 4'd3;
    cmd(3'd1, 0, "R8 eoi no vid");
    cmd(3'd3, 32'h20, "R10 tpr below thr");
    cmd(3'd3, 32'h30, "R10 tpr at thr");
    cmd(3'd4, 32'h0004_0060, "R11 icr valid but vid off");
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) fail("R2", "missing completions", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule